// File: doc/BRIEF.md
# Pattern-Test Error Counter

This block keeps a 16-bit tally of the errors that a pattern-test checker reports while a link runs a test pattern. In each clock cycle the checker presents one of two kinds of error indication. One is a flag that marks the current block as errored. The other is a 7-bit count of the errored bits in the current block. A mode input selects which of the two the block adds to its tally. The tally saturates at all ones and is cleared by the PCS reset.

Software reads the tally over an 8-bit register read port as two byte-wide registers at consecutive addresses. A read of the low byte returns the low eight bits. In the same cycle it copies the high eight bits into a shadow register and clears the live tally. A read of the high byte that follows returns that shadow. Software therefore gets a coherent 16-bit value if it reads the low byte first. Errors that arrive in the same cycle as the clearing read are kept and become the new tally.

Top module: `test_err_counter`

## Requirements
- R1: After reset the tally is zero, the shadow is zero and rd_data is zero, so reads of either byte return 0x00.
- R2: With count_bits = 0 (block mode), each cycle with blk_err = 1 adds exactly one to the tally, and bit_errs is ignored.
- R3: With count_bits = 1 (bit mode), each cycle adds the value of bit_errs (0 to 66) to the tally, and blk_err is ignored.
- R4: Any sum above 16'hFFFF leaves the tally at 16'hFFFF. The tally stays there under further errors until it is cleared.
- R5: A read with rd_addr = LO_ADDR (default 8'h10) puts the tally's bits [7:0] on rd_data in the cycle after the strobe. The value is the tally as it stood before that cycle's errors.
- R6: A low-byte read clears the tally. The error amount presented in the strobe cycle becomes the new tally, so those errors are not lost.
- R7: A read with rd_addr = LO_ADDR+1 returns bits [15:8] as captured by the most recent low-byte read, one cycle after the strobe. It leaves the tally and the shadow unchanged.
- R8: A read of any other address returns 0x00 one cycle later and does not change the tally.
- R9: Asserting rst in the middle of a test clears both the tally and the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high PCS reset |
| count_bits | input | 1 | 1 selects bit mode, 0 selects block mode |
| blk_err | input | 1 | The current block is errored (block mode) |
| bit_errs | input | 7 | Number of errored bits in the current block (bit mode) |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, registered, valid the cycle after rd_en |

## Verification
On every cycle the assertions check that a saturated tally holds unless it is being cleared, that a clearing read loads exactly the error amount from its strobe cycle, and that the tally never decreases without a clear. They also check that the shadow changes only on a low-byte read, that reads of unmapped addresses return zero, that low-byte and high-byte data match the tally and the shadow, and that reset empties the tally. Only the bench scenarios can show the end-to-end arithmetic against values computed independently. These are: a 300-block count split across two bytes, a sum of bit counts, saturation after a long run, a high-byte read that returns a stale shadow, errors that coincide with the clearing read, and reset in the middle of a test.

// File: rtl/tpec_pkg.sv
package tpec_pkg;
  typedef enum logic {
    MODE_BLOCK = 1'b0,
    MODE_BIT   = 1'b1
  } tally_mode_e;
endpackage

// File: rtl/err_incr.sv
module err_incr
  import tpec_pkg::*;
#(
  parameter int INC_W = 7
) (
  input  tally_mode_e      mode,
  input  logic             blk_err,
  input  logic [INC_W-1:0] bit_errs,
  output logic [INC_W-1:0] inc
);
  always_comb begin
    if (mode == MODE_BIT) inc = bit_errs;
    else                  inc = {{(INC_W-1){1'b0}}, blk_err};
  end

  // R2: block mode never adds more than one per cycle
  always_comb begin
    a_r2_block_unit: assert (mode == MODE_BIT || inc <= INC_W'(1));
  end
endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
  parameter int CNT_W = 16,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    sum = {1'b0, cnt} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    if (clr)           nxt = {{(CNT_W-INC_W){1'b0}}, inc};
    else if (sum[CNT_W]) nxt = MAXV;
    else               nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end

  a_r4_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV && !clr) |=> cnt == MAXV);
  a_r6_clear_load: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == {{(CNT_W-INC_W){1'b0}}, $past(inc)});
  a_r2_no_decrease: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt >= $past(cnt));
  a_r9_reset_empty: assert property (@(posedge clk)
    rst |=> cnt == '0);
endmodule

// File: rtl/rd_port.sv
module rd_port #(
  parameter int                CNT_W   = 16,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic              lo_rd,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NB   = CNT_W / DATA_W;
  localparam int SH_W = CNT_W - DATA_W;

  logic [NB-1:0]     hit;
  logic [DATA_W-1:0] byte_val [NB];
  logic [SH_W-1:0]   shadow;
  logic [DATA_W-1:0] nxt_data;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [ADDR_W-1:0] BA = LO_ADDR + ADDR_W'(k);
    assign hit[k] = rd_en && (rd_addr == BA);
    if (k == 0) begin : g_live
      assign byte_val[k] = cnt[DATA_W-1:0];
    end else begin : g_held
      assign byte_val[k] = shadow[(k-1)*DATA_W +: DATA_W];
    end
  end

  assign lo_rd = hit[0];

  always_comb begin
    nxt_data = '0;
    for (int k = 0; k < NB; k++)
      if (hit[k]) nxt_data = byte_val[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= nxt_data;
      if (lo_rd) shadow <= cnt[CNT_W-1:DATA_W];
    end
  end

  a_r7_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    !lo_rd |=> $stable(shadow));
  a_r7_hi_returns_shadow: assert property (@(posedge clk) disable iff (rst)
    hit[1] |=> rd_data == $past(shadow[DATA_W-1:0]));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit == '0) |=> rd_data == '0);
endmodule

// File: rtl/test_err_counter.sv
module test_err_counter
  import tpec_pkg::*;
#(
  parameter int                CNT_W   = 16,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter int                INC_W   = 7,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_bits,
  input  logic              blk_err,
  input  logic [INC_W-1:0]  bit_errs,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  tally_mode_e      mode;
  logic [INC_W-1:0] inc;
  logic [CNT_W-1:0] cnt;
  logic             lo_rd;

  assign mode = tally_mode_e'(count_bits);

  err_incr #(.INC_W(INC_W)) u_incr (
    .mode(mode), .blk_err(blk_err), .bit_errs(bit_errs), .inc(inc)
  );

  sat_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
    .clk(clk), .rst(rst), .clr(lo_rd), .inc(inc), .cnt(cnt)
  );

  rd_port #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) u_port (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .cnt(cnt),
    .lo_rd(lo_rd), .rd_data(rd_data)
  );

  a_r5_lo_byte: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> rd_data == $past(cnt[DATA_W-1:0]));
  a_r1_reset_data: assert property (@(posedge clk)
    rst |=> rd_data == '0);
endmodule

// File: tb/tb_test_err_counter.sv
module tb_test_err_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       count_bits = 1'b0;
  logic       blk_err = 1'b0;
  logic [6:0] bit_errs = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  localparam logic [7:0] LO = 8'h10;
  localparam logic [7:0] HI = 8'h11;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  test_err_counter dut (
    .clk(clk), .rst(rst), .count_bits(count_bits), .blk_err(blk_err),
    .bit_errs(bit_errs), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic run(input logic mode, input logic blk, input logic [6:0] bits, input int n);
    @(negedge clk);
    count_bits = mode; blk_err = blk; bit_errs = bits;
    repeat (n) @(negedge clk);
    blk_err = 1'b0; bit_errs = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = '0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rd_data after reset", rd_data, 8'h00);
    rd(LO, d); chk("R1 low byte after reset", d, 8'h00);
    rd(HI, d); chk("R1 high byte after reset", d, 8'h00);
  endtask

  task automatic t_block;
    logic [7:0] d;
    run(1'b0, 1'b1, 7'd50, 300);   // R2: bit_errs ignored
    run(1'b0, 1'b0, 7'd66, 5);
    rd(LO, d); chk("R5 R2 block low byte", d, 8'h2C);
    rd(HI, d); chk("R7 R2 block high byte", d, 8'h01);
    rd(LO, d); chk("R6 cleared after low read", d, 8'h00);
    rd(HI, d); chk("R7 high after empty read", d, 8'h00);
  endtask

  task automatic t_bit;
    logic [7:0] d;
    run(1'b1, 1'b1, 7'd0, 3);      // R3: blk_err ignored
    run(1'b1, 1'b0, 7'd66, 500);   // 33000 = 0x80E8
    rd(LO, d); chk("R3 bit low byte", d, 8'hE8);
    rd(HI, d); chk("R3 bit high byte", d, 8'h80);
  endtask

  task automatic t_sat;
    logic [7:0] d;
    run(1'b1, 1'b0, 7'd66, 1000);
    run(1'b1, 1'b0, 7'd66, 20);
    rd(HI, d); chk("R7 high before low gives stale shadow", d, 8'h80);
    rd(LO, d); chk("R4 saturated low", d, 8'hFF);
    rd(HI, d); chk("R4 saturated high", d, 8'hFF);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    run(1'b1, 1'b0, 7'd10, 5);
    @(negedge clk);
    bit_errs = 7'd7; rd_en = 1'b1; rd_addr = LO;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = '0; bit_errs = '0;
    chk("R6 R5 read value before same-cycle errors", rd_data, 8'h32);
    rd(LO, d); chk("R6 same-cycle errors kept", d, 8'h07);
    rd(HI, d); chk("R6 high after keep", d, 8'h00);
  endtask

  task automatic t_other;
    logic [7:0] d;
    run(1'b0, 1'b1, 7'd0, 5);
    rd(8'h33, d); chk("R8 unmapped returns zero", d, 8'h00);
    rd(8'h0F, d); chk("R8 address below low returns zero", d, 8'h00);
    rd(LO, d); chk("R8 tally untouched by unmapped read", d, 8'h05);
  endtask

  task automatic t_pcs_rst;
    logic [7:0] d;
    run(1'b0, 1'b1, 7'd0, 300);
    rd(LO, d); chk("R9 pre-reset low", d, 8'h2C);
    run(1'b0, 1'b1, 7'd0, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 rd_data after reset", rd_data, 8'h00);
    rd(HI, d); chk("R9 shadow cleared", d, 8'h00);
    rd(LO, d); chk("R9 tally cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_block();
    t_bit();
    t_sat();
    t_coincide();
    t_other();
    t_pcs_rst();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule